// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Decode

A byte-wide memory model that behaves like a field-programmable, ultraviolet-erasable read-only store. Five control levels are decoded into a mode: chip select, output gate and program strobe (all active low), a flag saying the programming supply is raised, and a flag saying the identifier address line is held at high voltage. From that mode the block reads the array, programs it, verifies it, or returns a fixed two-byte identifier. A drive-enable output stands in for a tri-state data bus.

Programming can only clear bits. A completed strobe pulse ANDs the input byte into the stored byte. Only the simulation erase input returns bits to 1. Reset also leaves the whole array erased. A strobe pulse writes only if programming conditions held on every sampled clock while the strobe was low. The write lands on the clock that first sees the strobe high again.

Top module: `otp_rom_ctrl`

## Requirements
- R1: After reset, and on the clock after `erase` is high, every address reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `sig_hv`=0, `dout_en`=1 and `dout` equals the stored byte at `addr`, whatever `pgm_n` is.
- R3: With `ce_n`=0 and `oe_n`=1, `dout_en`=0 and `dout`=0.
- R4: With `ce_n`=1, `dout_en`=0 whatever the other inputs are, and a strobe pulse in that state leaves the array unchanged (inhibit).
- R5: A completed program pulse stores old byte AND `din`, so a bit already at 0 stays 0.
- R6: Programming needs `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `sig_hv`=0 during a low pulse on `pgm_n`. The new byte is visible by the clock after `pgm_n` rises. A pulse whose first low sample fails those conditions writes nothing, even if they become true later.
- R7: Verify mode (`vpp_hi`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1, `sig_hv`=0) drives the stored byte.
- R8: If the programming conditions fail on any sampled cycle while `pgm_n` is low, that pulse writes nothing.
- R9: Identifier mode (`sig_hv`=1, `ce_n`=0, `oe_n`=0, `pgm_n`=1, `vpp_hi`=0) drives 0x20 when `addr[0]`=0 and 0x05 when `addr[0]`=1.
- R10: Any other control combination leaves `dout_en`=0 and `dout`=0. Examples are verify with the strobe low, and identifier mode with the supply raised or the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset; clears the strobe tracking and erases the array |
| erase | input | 1 | Simulation erase; sets every bit to 1 |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply is raised |
| sig_hv | input | 1 | Identifier address line at high voltage |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
All 32 combinations of the five control levels are swept with both values of `addr[0]` over a known array. This separates the two data sources (array and identifier) from the undriven state in every mode. The sweep runs with `din`=0xFF, so any strobe release it causes must leave the array intact. Every address is then programmed twice with different patterns. Overlapping zero bits expose any write that replaces the byte instead of ANDing into it. Further pulses are disturbed mid-way: the gate is dropped, the supply is lowered, the strobe falls before the mode is valid, and the chip is deselected. Each disturbance must leave the target byte unchanged, and a final erase must restore 0xFF everywhere.

// File: rtl/otp_rom_ctrl.sv
module otp_rom_ctrl #(
  parameter int          ADDR_W = 4,
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [7:0]  DEV_ID = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              sig_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic              pgm_q, armed;
  logic [ADDR_W-1:0] wa;
  logic [7:0]        wd;

  wire sig_rd  = !ce_n &  sig_hv & !oe_n & pgm_n & !vpp_hi;
  wire arr_rd  = !ce_n & !sig_hv & !oe_n & (!vpp_hi | pgm_n);
  wire prog_ok = !ce_n & !sig_hv &  oe_n & vpp_hi;
  wire wr_en   = !pgm_q & pgm_n & armed;

  assign dout_en = sig_rd | arr_rd;
  assign dout    = sig_rd ? (addr[0] ? DEV_ID : MFR_ID) :
                   arr_rd ? mem[addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_q <= 1'b1;
      armed <= 1'b0;
      wa    <= '0;
      wd    <= 8'hFF;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      pgm_q <= pgm_n;
      if (erase) begin
        armed <= 1'b0;
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (!pgm_n) begin
        armed <= pgm_q ? prog_ok : (armed & prog_ok);
        wa    <= addr;
        wd    <= din;
      end else begin
        armed <= 1'b0;
        if (wr_en) mem[wa] <= mem[wa] & wd;
      end
    end
  end

  p_armed_only_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !pgm_q);

  p_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> mem[$past(wa)] == ($past(mem[wa]) & $past(wd)));

  p_hold_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !erase) |=> mem[$past(addr)] == $past(mem[addr]));

  p_erase_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> mem[$past(addr)] == 8'hFF);

  p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

endmodule

// File: tb/otp_rom_ctrl_tb.sv
module otp_rom_ctrl_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0, erase = 0;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, sig_hv = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic [7:0] dout;
  logic dout_en;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [N];

  otp_rom_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .sig_hv(sig_hv), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en));

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got en/data %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ctl(logic c, logic o, logic p, logic v, logic h);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; sig_hv = h;
  endtask

  task automatic read_chk(string tag, logic [AW-1:0] a);
    @(negedge clk);
    addr = a; ctl(0, 0, 1, 0, 0);
    #1 chk(tag, {dout_en, dout}, {1'b1, model[a]});
  endtask

  task automatic pulse(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ctl(0, 1, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    repeat (2) @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state erased
    for (int a = 0; a < N; a++) read_chk("R1 reset", a[AW-1:0]);

    // R5: two passes with overlapping zeros; R2 read back
    for (int a = 0; a < N; a++) begin
      logic [7:0] v = 8'(a * 8'h3B) ^ 8'hA5;
      pulse(a[AW-1:0], v);
      model[a] &= v;
    end
    for (int a = 0; a < N; a++) begin
      logic [7:0] v = 8'h5A + 8'(a * 7);
      pulse(a[AW-1:0], v);
      model[a] &= v;
    end
    for (int a = 0; a < N; a++) read_chk("R5/R2 and-program", a[AW-1:0]);

    // R7: verify mode drives stored byte
    for (int a = 0; a < N; a += 5) begin
      @(negedge clk);
      addr = a[AW-1:0]; ctl(0, 0, 1, 1, 0);
      #1 chk("R7 verify", {dout_en, dout}, {1'b1, model[a]});
    end

    // R2,R3,R4,R9,R10: exhaustive control sweep
    din = 8'hFF;
    for (int k = 0; k < 64; k++) begin
      logic c, o, p, v, h;
      logic [8:0] e;
      {h, v, p, o, c} = k[4:0];
      @(negedge clk);
      addr = {{(AW-1){1'b0}}, k[5]};
      ctl(c, o, p, v, h);
      if (c) e = 9'h000;
      else if (h) e = (!o && p && !v) ? {1'b1, k[5] ? 8'h05 : 8'h20} : 9'h000;
      else if (!o && (!v || p)) e = {1'b1, model[addr]};
      else e = 9'h000;
      #1 chk($sformatf("R9/R10/R2/R3/R4 sweep %0d", k), {dout_en, dout}, e);
    end
    @(negedge clk) ctl(1, 1, 1, 0, 0);
    @(negedge clk);
    read_chk("R10 sweep no write a0", 0);
    read_chk("R10 sweep no write a1", 1);

    // R8: gate dropped mid-pulse
    @(negedge clk); addr = 3; din = 8'h00; ctl(0, 1, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    @(negedge clk) oe_n = 0;
    @(negedge clk) oe_n = 1;
    @(negedge clk) pgm_n = 1;
    @(negedge clk);
    read_chk("R8 gate glitch", 3);

    // R8: supply lowered mid-pulse
    @(negedge clk); addr = 4; din = 8'h00; ctl(0, 1, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    @(negedge clk) vpp_hi = 0;
    @(negedge clk) vpp_hi = 1;
    @(negedge clk) pgm_n = 1;
    @(negedge clk);
    read_chk("R8 supply drop", 4);

    // R6: strobe falls before mode valid
    @(negedge clk); addr = 5; din = 8'h00; ctl(0, 0, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    @(negedge clk) oe_n = 1;
    @(negedge clk) pgm_n = 1;
    @(negedge clk);
    read_chk("R6 late mode", 5);

    // R10: identifier line high during pulse
    @(negedge clk); addr = 6; din = 8'h00; ctl(0, 1, 1, 1, 1);
    @(negedge clk) pgm_n = 0;
    repeat (2) @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
    read_chk("R10 hv pulse", 6);

    // R4: inhibit
    @(negedge clk); addr = 7; din = 8'h00; ctl(1, 1, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    repeat (2) @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
    read_chk("R4 inhibit", 7);

    // R6: new byte visible one clock after release
    @(negedge clk); addr = 8; din = 8'h0F; ctl(0, 1, 1, 1, 0);
    @(negedge clk) pgm_n = 0;
    @(negedge clk) pgm_n = 1;
    @(negedge clk);
    model[8] &= 8'h0F;
    ctl(0, 0, 1, 1, 0);
    #1 chk("R6 visible after rise", {dout_en, dout}, {1'b1, model[8]});

    // R5: zero bits cannot be set back
    pulse(8, 8'hFF);
    read_chk("R5 no set", 8);

    // R1: erase
    @(negedge clk) erase = 1;
    @(negedge clk) erase = 0;
    for (int i = 0; i < N; i++) model[i] = 8'hFF;
    for (int a = 0; a < N; a++) read_chk("R1 erase", a[AW-1:0]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule